// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 64-bit byte address used by fixed-point load and store operations. Each cycle it may accept one request. A request carries a base register number and the value read for that register. It also carries an index register value, a 16-bit immediate, and a selector that chooses how the offset is built. The block adds a base term to an offset and registers the sum. A valid strobe comes out one cycle after the request.

Register number zero has a special meaning in the base position: it stands for the constant zero, and the value on the read port is not used. The offset is one of four kinds. It can be the whole immediate, sign-extended. It can be the upper 14 or upper 12 immediate bits with two or four zero bits placed below them before sign extension. It can be the full index register value. Decode, register reads, memory access and alignment checks are done by neighbouring logic.

Top module: `ls_ea_gen`

## Requirements
- R1: When `base_idx` is 0 the base term is 0 and `base_val` has no effect on `eff_addr`.
- R2: When `base_idx` is non-zero the base term is `base_val`.
- R3: With `form_sel` = 0 (whole-immediate form) the offset is `imm_field[15:0]` sign-extended to 64 bits.
- R4: With `form_sel` = 1 (word-scaled form) the offset is `{imm_field[15:2], 2'b00}` sign-extended, and `imm_field[1:0]` has no effect.
- R5: With `form_sel` = 2 (quad-scaled form) the offset is `{imm_field[15:4], 4'b0000}` sign-extended, and `imm_field[3:0]` has no effect.
- R6: With `form_sel` = 3 (indexed form) the offset is `index_val`, and `imm_field` has no effect.
- R7: The sum wraps modulo 2^64 and the carry out is dropped.
- R8: A request with `in_valid` high and a legal `form_sel` gives `out_valid` high and the address on `eff_addr` after exactly one rising clock edge.
- R9: A request whose `form_sel` is 4 to 7 gives `out_valid` low in the next cycle and leaves `eff_addr` unchanged.
- R10: A synchronous reset (`rst` high at a rising edge) clears `out_valid` and `eff_addr` to 0.
- R11: In a cycle after which no request was accepted, `out_valid` is low and `eff_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| form_sel | input | 3 | Offset form: 0 whole imm, 1 word-scaled, 2 quad-scaled, 3 indexed, 4-7 illegal |
| base_idx | input | 5 | Base register number; 0 means a zero base |
| base_val | input | 64 | Value read for the base register |
| index_val | input | 64 | Value read for the index register |
| imm_field | input | 16 | Immediate bits of the instruction |
| out_valid | output | 1 | Address on `eff_addr` is new this cycle |
| eff_addr | output | 64 | Registered effective address |

## Verification
Each offset form is tried with positive and with negative immediates. This shows whether the sign bit is taken from the correct field position after the zero bits are added. The scaled forms are driven with all-ones low immediate bits, which exposes any leakage of bits that should be dropped. A zero base register number is paired with a non-zero `base_val`, and the indexed form with a non-zero immediate, so that a wrongly selected source changes the result. Sums that cross 2^64 and illegal selectors mixed into back-to-back traffic check the wrap and the valid/hold behaviour.

// File: rtl/lsea_pkg.sv
package lsea_pkg;

    parameter int XLEN   = 64;
    parameter int IMM_W  = 16;
    parameter int RIDX_W = 5;
    parameter int FSEL_W = 3;

    typedef enum logic [FSEL_W-1:0] {
        FORM_D  = 3'd0,
        FORM_DS = 3'd1,
        FORM_DQ = 3'd2,
        FORM_X  = 3'd3
    } form_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] addr;
    } ea_res_t;

    function automatic logic form_is_legal(input logic [FSEL_W-1:0] f);
        return f <= FSEL_W'(FORM_X);
    endfunction

endpackage

// File: rtl/lsea_base_sel.sv
module lsea_base_sel #(
    parameter int XLEN   = lsea_pkg::XLEN,
    parameter int RIDX_W = lsea_pkg::RIDX_W
) (
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]   base_val,
    output logic [XLEN-1:0]   base_term
);
    // Register number zero in the base slot stands for a literal zero.
    always_comb begin
        if (base_idx == '0) base_term = '0;
        else                base_term = base_val;
    end
endmodule

// File: rtl/lsea_offset_gen.sv
module lsea_offset_gen
    import lsea_pkg::*;
#(
    parameter int XLEN  = lsea_pkg::XLEN,
    parameter int IMM_W = lsea_pkg::IMM_W,
    parameter int DS_ZB = 2,
    parameter int DQ_ZB = 4
) (
    input  logic [FSEL_W-1:0] form_sel,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [XLEN-1:0]   index_val,
    output logic [XLEN-1:0]   offset,
    output logic              legal
);
    localparam int EXT_W = XLEN - IMM_W;

    logic             sgn;
    logic [XLEN-1:0]  off_d, off_ds, off_dq;

    assign sgn    = imm_field[IMM_W-1];
    assign off_d  = {{EXT_W{sgn}}, imm_field};
    // Implied zero bits go in below the field before the sign is spread.
    assign off_ds = {{EXT_W{sgn}}, imm_field[IMM_W-1:DS_ZB], {DS_ZB{1'b0}}};
    assign off_dq = {{EXT_W{sgn}}, imm_field[IMM_W-1:DQ_ZB], {DQ_ZB{1'b0}}};

    always_comb begin
        legal = form_is_legal(form_sel);
        case (form_sel)
            FORM_D:  offset = off_d;
            FORM_DS: offset = off_ds;
            FORM_DQ: offset = off_dq;
            FORM_X:  offset = index_val;
            default: offset = '0;
        endcase
    end
endmodule

// File: rtl/lsea_sum_reg.sv
module lsea_sum_reg
    import lsea_pkg::*;
#(
    parameter int XLEN = lsea_pkg::XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            legal,
    input  logic [XLEN-1:0] base_term,
    input  logic [XLEN-1:0] offset,
    output ea_res_t         res
);
    logic [XLEN-1:0] sum;

    // Carry out of the top bit is simply not kept.
    assign sum = base_term + offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= take && legal;
            if (take && legal) res.addr <= sum;
        end
    end
endmodule

// File: rtl/ls_ea_gen.sv
module ls_ea_gen
    import lsea_pkg::*;
#(
    parameter int XLEN   = lsea_pkg::XLEN,
    parameter int IMM_W  = lsea_pkg::IMM_W,
    parameter int RIDX_W = lsea_pkg::RIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FSEL_W-1:0] form_sel,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic [IMM_W-1:0]  imm_field,
    output logic              out_valid,
    output logic [XLEN-1:0]   eff_addr
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] base_term, offset;
    logic            legal;
    ea_res_t         res;

    lsea_base_sel #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_base (
        .base_idx (base_idx),
        .base_val (base_val),
        .base_term(base_term)
    );

    lsea_offset_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
        .form_sel (form_sel),
        .imm_field(imm_field),
        .index_val(index_val),
        .offset   (offset),
        .legal    (legal)
    );

    lsea_sum_reg #(.XLEN(XLEN)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .take     (in_valid),
        .legal    (legal),
        .base_term(base_term),
        .offset   (offset),
        .res      (res)
    );

    assign out_valid = res.valid;
    assign eff_addr  = res.addr;

    // R8: a legal request shows up one edge later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel <= 3'd3) |=> out_valid);

    // R9: illegal selector never produces a valid result and leaves the address
    a_r9_illegal_drop: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel > 3'd3) |=> (!out_valid && $stable(eff_addr)));

    // R11: idle cycles keep the address
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(eff_addr)));

    // R1 and R6: zero base with indexed form passes the index value through
    a_r1_zero_base_idx: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 3'd3 && base_idx == '0) |=> eff_addr == $past(index_val));

    // R1 and R3: zero base with whole-immediate form gives the extended immediate
    a_r3_zero_base_imm: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 3'd0 && base_idx == '0) |=>
            eff_addr == {{EXT_W{$past(imm_field[IMM_W-1])}}, $past(imm_field)});
endmodule

// File: tb/tb_ls_ea_gen.sv
module tb_ls_ea_gen;

    typedef struct {
        logic        v;
        logic [63:0] a;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  form_sel = '0;
    logic [4:0]  base_idx = '0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic [15:0] imm_field = '0;
    logic        out_valid;
    logic [63:0] eff_addr;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t sb[$];
    logic [63:0] held = '0;

    always #5 clk = ~clk;

    ls_ea_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
        .base_idx(base_idx), .base_val(base_val), .index_val(index_val),
        .imm_field(imm_field), .out_valid(out_valid), .eff_addr(eff_addr)
    );

    function automatic logic [63:0] model(input logic [2:0] f, input logic [4:0] bi,
                                          input logic [63:0] bv, input logic [63:0] xv,
                                          input logic [15:0] im);
        logic [63:0] b, o;
        b = (bi == 5'd0) ? 64'd0 : bv;
        case (f)
            3'd0:    o = 64'($signed(im));
            3'd1:    o = 64'($signed({im[15:2], 2'b00}));
            3'd2:    o = 64'($signed({im[15:4], 4'b0000}));
            default: o = xv;
        endcase
        return b + o;
    endfunction

    task automatic drive(input logic v, input logic [2:0] f, input logic [4:0] bi,
                         input logic [63:0] bv, input logic [63:0] xv,
                         input logic [15:0] im, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v; form_sel = f; base_idx = bi;
        base_val = bv; index_val = xv; imm_field = im;
        e.v = v && (f <= 3'd3);
        if (e.v) held = model(f, bi, bv, xv, im);
        e.a = held;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one result per driven cycle, checked just after the edge.
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (out_valid !== e.v || eff_addr !== e.a) begin
                n_fail++;
                $display("FAIL %s: got v=%0b a=%h, expected v=%0b a=%h",
                         e.tag, out_valid, eff_addr, e.v, e.a);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || eff_addr !== 64'd0) begin
            n_fail++;
            $display("FAIL R10 reset: got v=%0b a=%h, expected v=0 a=0", out_valid, eff_addr);
        end

        drive(1, 3'd0, 5'd0,  64'hDEAD_BEEF_0000_1111, 64'h5, 16'h1234, "R1 zero base D");
        drive(1, 3'd0, 5'd7,  64'h0000_0000_0001_0000, 64'h0, 16'h0010, "R2 R3 D positive");
        drive(1, 3'd0, 5'd7,  64'h0000_0000_0001_0000, 64'h0, 16'hFFF0, "R3 D negative");
        drive(1, 3'd1, 5'd3,  64'h0000_0000_0000_1000, 64'h0, 16'h0007, "R4 DS low bits dropped");
        drive(1, 3'd1, 5'd3,  64'h0000_0000_0000_1000, 64'h0, 16'h8003, "R4 DS negative");
        drive(1, 3'd2, 5'd9,  64'h0000_0000_0000_2000, 64'h0, 16'h003F, "R5 DQ low bits dropped");
        drive(1, 3'd2, 5'd9,  64'h0000_0000_0000_2000, 64'h0, 16'hFFFF, "R5 DQ negative");
        drive(1, 3'd3, 5'd4,  64'h0000_0000_0000_0100, 64'h0000_0000_0000_0023, 16'h7FFF, "R6 X imm ignored");
        drive(1, 3'd3, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_1234_5678_9ABC, 16'h0000, "R1 R6 zero base X");
        drive(1, 3'd3, 5'd31, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 16'h0000, "R7 wrap X");
        drive(1, 3'd0, 5'd1,  64'h0000_0000_0000_0004, 64'h0, 16'h8000, "R7 wrap below zero");
        drive(1, 3'd5, 5'd2,  64'h1111, 64'h2222, 16'h0001, "R9 illegal 5");
        drive(1, 3'd7, 5'd2,  64'h3333, 64'h4444, 16'h0002, "R9 illegal 7");
        drive(0, 3'd0, 5'd2,  64'h5555, 64'h0, 16'h0003, "R11 idle hold");
        drive(1, 3'd1, 5'd0,  64'h9999, 64'h0, 16'hFFFE, "R1 R4 zero base DS");
        drive(1, 3'd4, 5'd0,  64'h0, 64'h0, 16'h0000, "R9 illegal 4");
        drive(1, 3'd2, 5'd12, 64'h0000_0000_0000_0000, 64'h0, 16'h7FF0, "R5 R8 DQ max positive");
        drive(0, 3'd3, 5'd1,  64'h1, 64'h1, 16'h0000, "R8 R11 idle after request");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R8: got %0d results pending, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule